// File: doc/BRIEF.md
# Compare and PWM Timer Channel

This block is one channel of a timer. It watches the value of a shared counter that sits outside the channel and drives one output pin. A counter tick strobe marks each cycle in which the counter presents a new value. A direction bit says whether that value was reached while counting down. The channel keeps its own compare value and detects a match when a tick carries a counter value equal to it. What the match does depends on a two-bit mode field and a two-bit level field. In compare mode the match sets, clears or toggles the pin, or leaves it alone. In pulse mode the match produces a single pulse one counter tick wide. In PWM mode the compare value sets the duty cycle, with edge-aligned or center-aligned timing and a selectable active level. Every match in an enabled mode raises a sticky event flag, which is cleared by a write-one strobe.

In PWM mode a new compare value waits in a shadow register. It reaches the comparator only on the tick where the counter is at zero, so a mid-period update cannot cut a period short or add an extra edge. In the other modes a write takes effect at once. All ports are plain control and status pins. No data stream passes through the channel, so there is no valid/ready handshake and no back-pressure.

Top module: `cmp_pwm_chan`

## Requirements
- R1: While reset is held and after it is released, `ch_out` is 0 and `ch_flag` is 0. Mode 00 (channel off) keeps `ch_out` at 0.
- R2: Mode 10 with `pwm_center`=0 is edge-aligned PWM. On the tick at counter value 0 the pin goes active, and on the tick where the counter equals the compare value it goes inactive. Over a period of ticks 0..M the pin is active for exactly C ticks.
- R3: Mode 10 with `pwm_center`=1 is center-aligned PWM over the sequence 0..M..1, with `cnt_dn`=1 on the falling half. The pin goes active at 0, goes inactive on the up-count match and goes active again on the down-count match. This gives 2*C active ticks out of 2*M.
- R4: In PWM mode, level 10 gives high-true pulses, level 01 gives low-true pulses (the pin is inverted), and levels 00 and 11 hold the pin at 0.
- R5: A PWM compare value of 0 gives a pin that is never active. A compare value greater than the top count M gives a pin that is always active.
- R6: In PWM mode a compare write takes effect only at the next tick with counter value 0. In modes 01 and 11 a write takes effect from the next cycle.
- R7: Mode 01 is output compare. On a match tick, level 00 leaves the pin unchanged, 01 toggles it, 10 clears it and 11 sets it. The pin changes in the cycle after the match tick.
- R8: Mode 11 is pulse compare. Level 01 idles low and drives high for one tick after a match. Level 10 idles high and drives low for one tick after a match. Levels 00 and 11 hold the pin at 0.
- R9: A match needs `cnt_tick`=1. A pulse level and all pin state hold through cycles without a tick.
- R10: A match tick in modes 01, 10 or 11 sets `ch_flag`, and mode 00 never sets it. `flag_clr`=1 clears the flag in the next cycle unless a match arrives in the same cycle, in which case the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Counter presents a new value this cycle |
| cnt_val | input | CW | Shared counter value |
| cnt_dn | input | 1 | Counter value was reached while counting down |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CW | Compare value to write |
| ch_mode | input | 2 | 00 off, 01 compare, 10 PWM, 11 pulse |
| ch_lvl | input | 2 | Action or active level select |
| pwm_center | input | 1 | 1 selects center-aligned PWM |
| flag_clr | input | 1 | Write-one clear of the event flag |
| ch_out | output | 1 | Channel pin |
| ch_flag | output | 1 | Sticky channel event flag |

## Verification
A wrong compare register shows at the pin on the first tick of the following period, because the count of active ticks differs from the compare value. A shadow value loaded early shows in the same period as an edge at the wrong tick. A wrong compare or pulse state register shows in `ch_out` in the cycle after the match tick. A pulse that ends early or late shows at the next tick. A flag that is set or cleared wrongly shows in `ch_flag` one cycle after the match or clear strobe.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    CH_OFF   = 2'b00,
    CH_OC    = 2'b01,
    CH_PWM   = 2'b10,
    CH_PULSE = 2'b11
  } ch_mode_e;

  localparam logic [1:0] LV_NONE  = 2'b00;
  localparam logic [1:0] LV_TOGL  = 2'b01;
  localparam logic [1:0] LV_CLR   = 2'b10;
  localparam logic [1:0] LV_SET   = 2'b11;
  localparam logic [1:0] LV_PHIGH = 2'b01;
  localparam logic [1:0] LV_PLOW  = 2'b10;
endpackage

// File: rtl/cpc_cmp_buf.sv
module cpc_cmp_buf #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_mode,
  input  logic          tick,
  input  logic [CW-1:0] cnt_val,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] eff_cmp,
  output logic          bnd,
  output logic          hit
);
  logic [CW-1:0] shadow_q;
  logic [CW-1:0] live_q;
  logic          pend_q;
  logic          swap;

  assign bnd     = tick && (cnt_val == '0);
  assign swap    = pwm_mode && bnd && pend_q;
  assign eff_cmp = swap ? shadow_q : live_q;
  assign hit     = tick && (cnt_val == eff_cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      live_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (swap) begin
        live_q <= shadow_q;
        pend_q <= 1'b0;
      end
      if (wr) begin
        shadow_q <= wdata;
        if (pwm_mode) begin
          pend_q <= 1'b1;
        end else begin
          live_q <= wdata;
          pend_q <= 1'b0;
        end
      end
    end
  end

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !bnd) |=> $stable(live_q));
endmodule

// File: rtl/cpc_oc_unit.sv
module cpc_oc_unit
  import cpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ch_mode_e   mode,
  input  logic [1:0] lvl,
  input  logic       tick,
  input  logic       hit,
  output logic       oc_pin,
  output logic       pls_pin
);
  logic oc_q;
  logic pls_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc_q  <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      if (mode == CH_OC && hit) begin
        case (lvl)
          LV_TOGL: oc_q <= ~oc_q;
          LV_CLR:  oc_q <= 1'b0;
          LV_SET:  oc_q <= 1'b1;
          default: oc_q <= oc_q;
        endcase
      end
      if (mode != CH_PULSE) pls_q <= 1'b0;
      else if (tick)        pls_q <= hit;
    end
  end

  assign oc_pin = oc_q;

  always_comb begin
    case (lvl)
      LV_PHIGH: pls_pin = pls_q;
      LV_PLOW:  pls_pin = ~pls_q;
      default:  pls_pin = 1'b0;
    endcase
  end

  // R7
  oc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_OC && hit && lvl == LV_SET) |=> oc_q);
  // R9
  oc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick) |=> $stable(oc_q));
  // R8
  pulse_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_PULSE && hit) |=> pls_q);
endmodule

// File: rtl/cpc_pwm_unit.sv
module cpc_pwm_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic center,
  input  logic dn,
  input  logic tick,
  input  logic bnd,
  input  logic hit,
  input  logic eff_zero,
  output logic act
);
  logic act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (en && bnd) begin
      act_q <= !eff_zero;
    end else if (en && hit) begin
      act_q <= center ? dn : 1'b0;
    end
  end

  assign act = act_q;

  // R9
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick) |=> $stable(act_q));
  // R3
  pwm_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && center && dn && hit && !bnd) |=> act_q);
endmodule

// File: rtl/cmp_pwm_chan.sv
module cmp_pwm_chan
  import cpc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_dn,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  input  logic [1:0]    ch_mode,
  input  logic [1:0]    ch_lvl,
  input  logic          pwm_center,
  input  logic          flag_clr,
  output logic          ch_out,
  output logic          ch_flag
);
  ch_mode_e      md;
  logic [CW-1:0] eff_cmp;
  logic          bnd, hit, evt;
  logic          oc_pin, pls_pin, pwm_act;
  logic          flag_q;

  assign md  = ch_mode_e'(ch_mode);
  assign evt = hit && (md != CH_OFF);

  cpc_cmp_buf #(.CW(CW)) u_buf (
    .clk(clk), .rst_n(rst_n), .pwm_mode(md == CH_PWM), .tick(cnt_tick),
    .cnt_val(cnt_val), .wr(cmp_wr), .wdata(cmp_wdata),
    .eff_cmp(eff_cmp), .bnd(bnd), .hit(hit)
  );

  cpc_oc_unit u_oc (
    .clk(clk), .rst_n(rst_n), .mode(md), .lvl(ch_lvl), .tick(cnt_tick),
    .hit(hit), .oc_pin(oc_pin), .pls_pin(pls_pin)
  );

  cpc_pwm_unit u_pwm (
    .clk(clk), .rst_n(rst_n), .en(md == CH_PWM), .center(pwm_center),
    .dn(cnt_dn), .tick(cnt_tick), .bnd(bnd), .hit(hit),
    .eff_zero(eff_cmp == '0), .act(pwm_act)
  );

  always_comb begin
    case (md)
      CH_OC:    ch_out = oc_pin;
      CH_PULSE: ch_out = pls_pin;
      CH_PWM: begin
        case (ch_lvl)
          2'b10:   ch_out = pwm_act;
          2'b01:   ch_out = ~pwm_act;
          default: ch_out = 1'b0;
        endcase
      end
      default:  ch_out = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (evt)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign ch_flag = flag_q;

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> ch_flag);
  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !evt) |=> !ch_flag);
  // R1
  off_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (md == CH_OFF) |-> !ch_out);
endmodule

// File: tb/sim_cmp_pwm_chan.sv
`timescale 1ns/1ps
module sim_cmp_pwm_chan;
  localparam int CW   = 16;
  localparam int MODV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_tick = 1'b0, cnt_dn = 1'b0, cmp_wr = 1'b0, pwm_center = 1'b0, flag_clr = 1'b0;
  logic [CW-1:0] cnt_val = '0, cmp_wdata = '0;
  logic [1:0] ch_mode = 2'b00, ch_lvl = 2'b00;
  logic ch_out, ch_flag;

  always #2.5 clk = ~clk;

  cmp_pwm_chan #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
    .cnt_dn(cnt_dn), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .ch_mode(ch_mode), .ch_lvl(ch_lvl), .pwm_center(pwm_center),
    .flag_clr(flag_clr), .ch_out(ch_out), .ch_flag(ch_flag)
  );

  int checks = 0;
  int errs = 0;
  logic samp [0:31];
  int cnt_hi;
  logic pin_s;

  // {center, level, compare, expected active ticks per period}
  localparam logic [18:0] VEC [0:11] = '{
    {1'b0, 2'b10, 8'd3,  8'd3},   // R2 edge high-true
    {1'b0, 2'b01, 8'd3,  8'd7},   // R4 edge low-true
    {1'b0, 2'b10, 8'd0,  8'd0},   // R5 0% duty
    {1'b0, 2'b10, 8'd10, 8'd10},  // R5 100% duty
    {1'b0, 2'b01, 8'd0,  8'd10},  // R5 low-true 0%
    {1'b0, 2'b01, 8'd10, 8'd0},   // R5 low-true 100%
    {1'b0, 2'b00, 8'd3,  8'd0},   // R4 no output
    {1'b1, 2'b10, 8'd3,  8'd6},   // R3 center high-true
    {1'b1, 2'b01, 8'd3,  8'd12},  // R3 center low-true
    {1'b1, 2'b10, 8'd0,  8'd0},   // R5 center 0%
    {1'b1, 2'b10, 8'd10, 8'd18},  // R5 center 100%
    {1'b1, 2'b11, 8'd1,  8'd0}    // R4 center no output
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int v, input bit dn, input bit tk,
                      input bit wr, input int wd, input bit clr);
    cnt_val = CW'(v); cnt_dn = dn; cnt_tick = tk;
    cmp_wr = wr; cmp_wdata = CW'(wd); flag_clr = clr;
    @(posedge clk);
    #1;
    cmp_wr = 1'b0; flag_clr = 1'b0; cnt_tick = 1'b0;
    pin_s = ch_out;
  endtask

  task automatic setcmp(input int val);
    step(0, 1'b0, 1'b0, 1'b1, val, 1'b0);
  endtask

  task automatic run_period(input bit ctr, input int wr_at, input int wd);
    int len;
    len = ctr ? 2*MODV : MODV+1;
    cnt_hi = 0;
    for (int i = 0; i < len; i++) begin
      int v;
      bit dn;
      if (!ctr || i <= MODV) begin v = i; dn = 1'b0; end
      else begin v = 2*MODV - i; dn = 1'b1; end
      step(v, dn, 1'b1, (i == wr_at), wd, 1'b0);
      samp[i] = pin_s;
      if (pin_s) cnt_hi++;
    end
  endtask

  initial begin
    #1000000;
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(ch_out == 1'b0, "R1", "pin in reset", int'(ch_out), 0);
    chk(ch_flag == 1'b0, "R1", "flag in reset", int'(ch_flag), 0);
    rst_n = 1'b1;
    step(0, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    chk(pin_s == 1'b0 && ch_flag == 1'b0, "R1", "off after reset", int'(pin_s), 0);

    // PWM vector table: R2 R3 R4 R5
    ch_mode = 2'b10;
    for (int k = 0; k < 12; k++) begin
      pwm_center = VEC[k][18];
      ch_lvl     = VEC[k][17:16];
      setcmp(int'(VEC[k][15:8]));
      run_period(VEC[k][18], -1, 0);
      run_period(VEC[k][18], -1, 0);
      chk(cnt_hi == int'(VEC[k][7:0]), "R2-R5 vec", $sformatf("entry %0d active ticks", k),
          cnt_hi, int'(VEC[k][7:0]));
    end

    // R6 shadow compare in PWM
    pwm_center = 1'b0; ch_lvl = 2'b10;
    setcmp(3);
    run_period(1'b0, -1, 0);
    run_period(1'b0, 2, 6);
    chk(cnt_hi == 3, "R6", "write mid-period ignored this period", cnt_hi, 3);
    run_period(1'b0, -1, 0);
    chk(cnt_hi == 6, "R6", "new compare at next period", cnt_hi, 6);
    chk(samp[5] == 1'b1, "R6", "pin after tick 5", int'(samp[5]), 1);

    // R7 compare actions
    ch_mode = 2'b01; setcmp(5);
    ch_lvl = 2'b11; run_period(1'b0, -1, 0);
    chk(samp[4] == 1'b0 && samp[5] == 1'b1, "R7", "set at tick 5", int'(samp[5]), 1);
    ch_lvl = 2'b10; run_period(1'b0, -1, 0);
    chk(samp[4] == 1'b1 && samp[5] == 1'b0, "R7", "clear at tick 5", int'(samp[5]), 0);
    ch_lvl = 2'b01; run_period(1'b0, -1, 0);
    chk(samp[4] == 1'b0 && samp[5] == 1'b1, "R7", "toggle up", int'(samp[5]), 1);
    run_period(1'b0, -1, 0);
    chk(samp[4] == 1'b1 && samp[5] == 1'b0, "R7", "toggle down", int'(samp[5]), 0);
    ch_lvl = 2'b00; run_period(1'b0, -1, 0);
    chk(cnt_hi == 0, "R7", "no change action", cnt_hi, 0);

    // R6 immediate load outside PWM
    ch_lvl = 2'b11; run_period(1'b0, 3, 7);
    chk(samp[5] == 1'b0 && samp[6] == 1'b0, "R6", "old compare gone", int'(samp[5]), 0);
    chk(samp[7] == 1'b1, "R6", "new compare used at once", int'(samp[7]), 1);

    // R8 pulses
    ch_mode = 2'b11; setcmp(5);
    ch_lvl = 2'b01; run_period(1'b0, -1, 0);
    chk(samp[5] == 1'b1 && samp[6] == 1'b0, "R8", "high pulse", int'(samp[5]), 1);
    chk(cnt_hi == 1, "R8", "high pulse width", cnt_hi, 1);
    ch_lvl = 2'b10; run_period(1'b0, -1, 0);
    chk(samp[5] == 1'b0, "R8", "low pulse", int'(samp[5]), 0);
    chk(cnt_hi == 9, "R8", "low pulse idle high", cnt_hi, 9);

    // R9 tick gating
    ch_lvl = 2'b01;
    step(5, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    chk(pin_s == 1'b1, "R9", "pulse starts", int'(pin_s), 1);
    for (int j = 0; j < 3; j++) begin
      step(5, 1'b0, 1'b0, 1'b0, 0, 1'b0);
      chk(pin_s == 1'b1, "R9", "pulse held without tick", int'(pin_s), 1);
    end
    step(6, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    chk(pin_s == 1'b0, "R9", "pulse ends on next tick", int'(pin_s), 0);

    // R10 flag
    step(0, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    chk(ch_flag == 1'b0, "R10", "flag cleared", int'(ch_flag), 0);
    step(5, 1'b0, 1'b1, 1'b0, 0, 1'b1);
    chk(ch_flag == 1'b1, "R10", "set wins over clear", int'(ch_flag), 1);
    step(0, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    ch_mode = 2'b00; run_period(1'b0, -1, 0);
    chk(ch_flag == 1'b0, "R10", "no flag when off", int'(ch_flag), 0);
    chk(cnt_hi == 0, "R1", "pin low when off", cnt_hi, 0);
    ch_mode = 2'b01; ch_lvl = 2'b00; run_period(1'b0, -1, 0);
    chk(ch_flag == 1'b1, "R10", "flag on match without pin change", int'(ch_flag), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule